// File: doc/BRIEF.md
# I2C Byte Holding Registers with Status and Interrupt Logic

This block sits between a host or DMA bus and the bit-level shifting logic of an I2C controller. It keeps one transmit byte and one received byte. For each of the two it reports whether the slot is in use. The bus side writes outgoing bytes into the transmit slot. The shift side takes them through a valid/ready handshake. Bytes that the shift side completes are placed in the receive slot, and the bus side reads them from there.

Software learns when to act from two request flags and one combined interrupt line. The transmit request depends on how many bytes remain to be sent, which arrives as an input count. Misuse is recorded in sticky error bits. A write into an occupied transmit slot is dropped and flagged. A read of an empty receive slot is flagged and also sends a one-cycle not-acknowledge request to the protocol engine. While an error bit is set, its direction is frozen until software clears that bit. A single clear pulse empties both slots at once.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset a few clock edges after the input rises.

Top module: `i2c_buf_regs`

## Requirements
- R1: After reset, tx_empty=1, txs_valid=0, txs_data=0, rx_full=0, host_rdata=0, and tx_flag, rx_flag, irq, tx_wr_err, rx_rd_err and nack_req are all 0.
- R2: A host_wr while tx_empty=1, tx_wr_err=0 and clr_bufs=0 stores host_wdata. From the next edge, tx_empty=0, txs_valid=1 and txs_data shows the stored byte.
- R3: tx_flag is a register. At each edge it takes the value 1 exactly when the slot will be empty after that edge, byte_count is nonzero, and clr_bufs is 0. As a result, an accepted write clears it at the same edge that fills the slot.
- R4: irq = (tx_flag AND tx_ie) OR (rx_flag AND rx_ie), combinationally.
- R5: A host_wr while tx_empty=0 (and clr_bufs=0) sets tx_wr_err at the next edge. The written byte is discarded, and txs_data and tx_empty are unchanged.
- R6: An rxs_valid cycle, when rx_rd_err=0 and clr_bufs=0, stores rxs_data. At the next edge it sets rx_full and rx_flag and shows the byte on host_rdata. A new byte overwrites a byte that is still unread.
- R7: A host_rd while rx_full=1 clears rx_full and rx_flag at the next edge. If rxs_valid is high in the same cycle, the new byte is stored instead and rx_full stays 1.
- R8: A host_rd while rx_full=0 and rx_rd_err=0 sets rx_rd_err at the next edge and drives nack_req high for exactly one cycle.
- R9: Each error bit stays set until its own clear input (clr_tx_err, clr_rx_err) is pulsed, and a new error event in that same cycle wins over the clear. While tx_wr_err=1, txs_valid=0 and writes are not stored. While rx_rd_err=1, incoming bytes and reads have no effect.
- R10: A cycle with txs_valid=1 and txs_ready=1 hands the byte over, and tx_empty is 1 from the next edge.
- R11: A clr_bufs cycle makes tx_empty=1, rx_full=0, tx_flag=0 and rx_flag=0 at the next edge. It takes precedence over a write or an incoming byte in the same cycle. The byte registers keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe for the transmit slot |
| host_wdata | input | DATA_W | Byte to write |
| host_rd | input | 1 | Read strobe for the receive slot |
| host_rdata | output | DATA_W | Content of the receive slot |
| byte_count | input | CNT_W | Bytes still to be transferred |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| clr_bufs | input | 1 | One-cycle clear of both slots and both request flags |
| clr_tx_err | input | 1 | Clears tx_wr_err |
| clr_rx_err | input | 1 | Clears rx_rd_err |
| txs_valid | output | 1 | Transmit byte offered to the shift side |
| txs_data | output | DATA_W | Byte offered to the shift side |
| txs_ready | input | 1 | Shift side takes the offered byte |
| rxs_valid | input | 1 | Shift side delivers a completed byte |
| rxs_data | input | DATA_W | Completed byte |
| tx_empty | output | 1 | Transmit slot free |
| tx_flag | output | 1 | Transmit request flag |
| tx_wr_err | output | 1 | Sticky write-while-full error |
| rx_full | output | 1 | Receive slot holds an unread byte |
| rx_flag | output | 1 | Receive request flag |
| rx_rd_err | output | 1 | Sticky read-while-empty error |
| nack_req | output | 1 | One-cycle not-acknowledge request |
| irq | output | 1 | Combined interrupt |

## Verification
All state sits in registers one edge behind the strobes, so a wrong occupancy bit shows at the ports one cycle after the faulty stimulus. It appears as a wrong tx_empty or rx_full, a txs_valid that should not be offered, or a flag and irq that go the wrong way. A lost or spurious error latch shows in the same cycle as a missing or extra nack_req pulse. It also shows in the cycles after it, because writes stay frozen or reads keep being honoured when they should not. The byte registers are checked through txs_data and host_rdata after drops, overwrites and clears, so a wrong clock enable shows at once as a wrong byte.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_CNT_W  = 8;
  localparam int unsigned DEF_SYNC   = 2;

  // what the transmit slot does at the next edge
  typedef enum logic [1:0] {
    TX_HOLD,
    TX_LOAD,
    TX_SENT,
    TX_FLUSH
  } tx_act_e;

  // what the receive slot does at the next edge
  typedef enum logic [1:0] {
    RX_HOLD,
    RX_LOAD,
    RX_DRAIN,
    RX_FLUSH
  } rx_act_e;

endpackage

// File: rtl/ibr_rst_sync.sv
module ibr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  localparam int unsigned NST = (STAGES < 2) ? 2 : STAGES;

  logic [NST-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[NST-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[NST-1];

endmodule

// File: rtl/ibr_tx_slot.sv
module ibr_tx_slot
  import ibr_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cnt_nz,
  input  logic              clr_buf,
  input  logic              clr_err,
  input  logic              shf_ready,
  output logic              shf_valid,
  output logic [DATA_W-1:0] shf_data,
  output logic              empty,
  output logic              flag,
  output logic              err
);

  tx_act_e           act;
  logic              empty_q, empty_d;
  logic              flag_q, flag_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] data_q;
  logic              data_en;
  logic              wr_ok, wr_bad, handoff;

  assign shf_valid = !empty_q && !err_q;
  assign handoff   = shf_valid && shf_ready;
  assign wr_ok     = wr_en && empty_q && !err_q && !clr_buf;
  assign wr_bad    = wr_en && !empty_q && !clr_buf;

  always_comb begin
    if (clr_buf)      act = TX_FLUSH;
    else if (handoff) act = TX_SENT;
    else if (wr_ok)   act = TX_LOAD;
    else              act = TX_HOLD;
  end

  always_comb begin
    empty_d = empty_q;
    data_en = 1'b0;
    unique case (act)
      TX_FLUSH: empty_d = 1'b1;
      TX_SENT:  empty_d = 1'b1;
      TX_LOAD: begin
        empty_d = 1'b0;
        data_en = 1'b1;
      end
      default:  empty_d = empty_q;
    endcase
    flag_d = empty_d && cnt_nz && !clr_buf;
    if (wr_bad)       err_d = 1'b1;
    else if (clr_err) err_d = 1'b0;
    else              err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      flag_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      empty_q <= empty_d;
      flag_q  <= flag_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= wr_data;
    end
  end

  assign shf_data = data_q;
  assign empty    = empty_q;
  assign flag     = flag_q;
  assign err      = err_q;

  AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && empty && !err && !clr_buf |=> !empty && !flag && shf_data == $past(wr_data)); // R2
  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !empty && !clr_buf |=> err && $stable(shf_data)); // R5
  AST_TX_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    shf_valid && shf_ready |=> empty); // R10
  AST_TX_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clr_err |=> err); // R9
  AST_TX_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !shf_valid); // R9

endmodule

// File: rtl/ibr_rx_slot.sv
module ibr_rx_slot
  import ibr_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shf_valid,
  input  logic [DATA_W-1:0] shf_data,
  input  logic              rd_en,
  input  logic              clr_buf,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              flag,
  output logic              err,
  output logic              nack
);

  rx_act_e           act;
  logic              full_q, full_d;
  logic              flag_q, flag_d;
  logic              err_q, err_d;
  logic              nack_q, nack_d;
  logic [DATA_W-1:0] data_q;
  logic              data_en;
  logic              store, rd_good, rd_bad;

  assign store   = shf_valid && !err_q && !clr_buf;
  assign rd_good = rd_en && full_q && !err_q && !clr_buf;
  assign rd_bad  = rd_en && !full_q && !err_q;

  always_comb begin
    if (clr_buf)      act = RX_FLUSH;
    else if (store)   act = RX_LOAD;
    else if (rd_good) act = RX_DRAIN;
    else              act = RX_HOLD;
  end

  always_comb begin
    full_d  = full_q;
    flag_d  = flag_q;
    data_en = 1'b0;
    unique case (act)
      RX_FLUSH: begin
        full_d = 1'b0;
        flag_d = 1'b0;
      end
      RX_LOAD: begin
        full_d  = 1'b1;
        flag_d  = 1'b1;
        data_en = 1'b1;
      end
      RX_DRAIN: begin
        full_d = 1'b0;
        flag_d = 1'b0;
      end
      default: begin
        full_d = full_q;
        flag_d = flag_q;
      end
    endcase
    if (rd_bad)       err_d = 1'b1;
    else if (clr_err) err_d = 1'b0;
    else              err_d = err_q;
    nack_d = rd_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      flag_q <= 1'b0;
      err_q  <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      full_q <= full_d;
      flag_q <= flag_d;
      err_q  <= err_d;
      nack_q <= nack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= shf_data;
    end
  end

  assign rd_data = data_q;
  assign full    = full_q;
  assign flag    = flag_q;
  assign err     = err_q;
  assign nack    = nack_q;

  AST_RX_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    shf_valid && !err && !clr_buf |=> full && flag && rd_data == $past(shf_data)); // R6
  AST_RX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && full && !err && !shf_valid && !clr_buf |=> !full && !flag); // R7
  AST_RX_BAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !full && !err |=> nack && err); // R8
  AST_RX_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clr_err |=> err && $stable(rd_data)); // R9

endmodule

// File: rtl/i2c_buf_regs.sv
module i2c_buf_regs
  import ibr_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned SYNC_N = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              tx_ie,
  input  logic              rx_ie,
  input  logic              clr_bufs,
  input  logic              clr_tx_err,
  input  logic              clr_rx_err,
  output logic              txs_valid,
  output logic [DATA_W-1:0] txs_data,
  input  logic              txs_ready,
  input  logic              rxs_valid,
  input  logic [DATA_W-1:0] rxs_data,
  output logic              tx_empty,
  output logic              tx_flag,
  output logic              tx_wr_err,
  output logic              rx_full,
  output logic              rx_flag,
  output logic              rx_rd_err,
  output logic              nack_req,
  output logic              irq
);

  logic rst_n_s;
  logic cnt_nz;

  ibr_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  assign cnt_nz = |byte_count;

  ibr_tx_slot #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (host_wr),
    .wr_data   (host_wdata),
    .cnt_nz    (cnt_nz),
    .clr_buf   (clr_bufs),
    .clr_err   (clr_tx_err),
    .shf_ready (txs_ready),
    .shf_valid (txs_valid),
    .shf_data  (txs_data),
    .empty     (tx_empty),
    .flag      (tx_flag),
    .err       (tx_wr_err)
  );

  ibr_rx_slot #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .shf_valid (rxs_valid),
    .shf_data  (rxs_data),
    .rd_en     (host_rd),
    .clr_buf   (clr_bufs),
    .clr_err   (clr_rx_err),
    .rd_data   (host_rdata),
    .full      (rx_full),
    .flag      (rx_flag),
    .err       (rx_rd_err),
    .nack      (nack_req)
  );

  assign irq = (tx_flag && tx_ie) || (rx_flag && rx_ie);

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n_s)
    clr_bufs |=> tx_empty && !rx_full && !tx_flag && !rx_flag); // R11
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n_s)
    !tx_ie && !rx_ie |-> !irq); // R4
  AST_TXFLAG_NEEDS_CNT: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cnt_nz |=> !tx_flag); // R3

endmodule

// File: tb/i2c_buf_regs_test.sv
module i2c_buf_regs_test;

  typedef struct packed {
    logic       wr;   logic [7:0] wd;  logic rd;  logic rxv; logic [7:0] rxd;
    logic       rdy;  logic [7:0] cnt; logic clr; logic cte; logic cre;
    logic [3:0] req;
    logic       e_txe; logic e_txv; logic [7:0] e_txd; logic e_rxf; logic e_txf;
    logic       e_rxfl; logic e_irq; logic e_terr; logic e_rerr; logic e_nk;
    logic [7:0] e_rdd;
  } vec_t;

  localparam int NV = 18;
  // wr wd rd rxv rxd rdy cnt clr cte cre req | txe txv txd rxf txf rxfl irq terr rerr nk rdd
  localparam vec_t VT [NV] = '{
    '{0,8'h00,0,0,8'h00,0,8'd3,0,0,0,4'd3,  1,0,8'h00,0,1,0,1,0,0,0,8'h00}, // R3 flag rises
    '{1,8'hA5,0,0,8'h00,0,8'd3,0,0,0,4'd2,  0,1,8'hA5,0,0,0,0,0,0,0,8'h00}, // R2 accept
    '{1,8'h3C,0,0,8'h00,0,8'd3,0,0,0,4'd5,  0,0,8'hA5,0,0,0,0,1,0,0,8'h00}, // R5 drop
    '{0,8'h00,0,0,8'h00,1,8'd3,0,0,0,4'd9,  0,0,8'hA5,0,0,0,0,1,0,0,8'h00}, // R9 frozen
    '{0,8'h00,0,0,8'h00,0,8'd3,0,1,0,4'd9,  0,1,8'hA5,0,0,0,0,0,0,0,8'h00}, // R9 clear
    '{0,8'h00,0,0,8'h00,1,8'd3,0,0,0,4'd10, 1,0,8'hA5,0,1,0,1,0,0,0,8'h00}, // R10 handoff
    '{0,8'h00,0,0,8'h00,0,8'd0,0,0,0,4'd3,  1,0,8'hA5,0,0,0,0,0,0,0,8'h00}, // R3 count zero
    '{0,8'h00,0,1,8'h5A,0,8'd0,0,0,0,4'd6,  1,0,8'hA5,1,0,1,1,0,0,0,8'h5A}, // R6 store
    '{0,8'h00,0,1,8'h77,0,8'd0,0,0,0,4'd6,  1,0,8'hA5,1,0,1,1,0,0,0,8'h77}, // R6 overwrite
    '{0,8'h00,1,1,8'h11,0,8'd0,0,0,0,4'd7,  1,0,8'hA5,1,0,1,1,0,0,0,8'h11}, // R7 read+arrive
    '{0,8'h00,1,0,8'h00,0,8'd0,0,0,0,4'd7,  1,0,8'hA5,0,0,0,0,0,0,0,8'h11}, // R7 drain
    '{0,8'h00,1,0,8'h00,0,8'd0,0,0,0,4'd8,  1,0,8'hA5,0,0,0,0,0,1,1,8'h11}, // R8 bad read
    '{0,8'h00,0,0,8'h00,0,8'd0,0,0,0,4'd8,  1,0,8'hA5,0,0,0,0,0,1,0,8'h11}, // R8 one pulse
    '{0,8'h00,0,1,8'h22,0,8'd0,0,0,0,4'd9,  1,0,8'hA5,0,0,0,0,0,1,0,8'h11}, // R9 rx frozen
    '{0,8'h00,0,0,8'h00,0,8'd0,0,0,1,4'd9,  1,0,8'hA5,0,0,0,0,0,0,0,8'h11}, // R9 rx clear
    '{1,8'h44,0,1,8'h33,0,8'd0,0,0,0,4'd2,  0,1,8'h44,1,0,1,1,0,0,0,8'h33}, // R2 both sides
    '{0,8'h00,0,1,8'h99,0,8'd5,1,0,0,4'd11, 1,0,8'h44,0,0,0,0,0,0,0,8'h33}, // R11 clear wins
    '{0,8'h00,0,0,8'h00,0,8'd5,0,0,0,4'd3,  1,0,8'h44,0,1,0,1,0,0,0,8'h33}  // R3 re-arm
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr, host_rd, tx_ie, rx_ie, clr_bufs, clr_tx_err, clr_rx_err;
  logic       txs_ready, rxs_valid;
  logic [7:0] host_wdata, rxs_data, byte_count;
  logic [7:0] host_rdata, txs_data;
  logic       txs_valid, tx_empty, tx_flag, tx_wr_err, rx_full, rx_flag, rx_rd_err;
  logic       nack_req, irq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  i2c_buf_regs uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .byte_count(byte_count),
    .tx_ie(tx_ie), .rx_ie(rx_ie), .clr_bufs(clr_bufs), .clr_tx_err(clr_tx_err),
    .clr_rx_err(clr_rx_err), .txs_valid(txs_valid), .txs_data(txs_data),
    .txs_ready(txs_ready), .rxs_valid(rxs_valid), .rxs_data(rxs_data),
    .tx_empty(tx_empty), .tx_flag(tx_flag), .tx_wr_err(tx_wr_err),
    .rx_full(rx_full), .rx_flag(rx_flag), .rx_rd_err(rx_rd_err),
    .nack_req(nack_req), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 0; host_wdata = 0; host_rd = 0; rxs_valid = 0; rxs_data = 0;
    txs_ready = 0; clr_bufs = 0; clr_tx_err = 0; clr_rx_err = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; idle(); byte_count = 0; tx_ie = 1; rx_ie = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 tx_empty", {7'd0, tx_empty}, 8'd1);
    chk("R1 txs_valid", {7'd0, txs_valid}, 8'd0);
    chk("R1 txs_data", txs_data, 8'h00);
    chk("R1 rx_full", {7'd0, rx_full}, 8'd0);
    chk("R1 host_rdata", host_rdata, 8'h00);
    chk("R1 flags irq", {4'd0, tx_flag, rx_flag, irq, nack_req}, 8'd0);
    chk("R1 errors", {6'd0, tx_wr_err, rx_rd_err}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      host_wr = VT[i].wr; host_wdata = VT[i].wd; host_rd = VT[i].rd;
      rxs_valid = VT[i].rxv; rxs_data = VT[i].rxd; txs_ready = VT[i].rdy;
      byte_count = VT[i].cnt; clr_bufs = VT[i].clr;
      clr_tx_err = VT[i].cte; clr_rx_err = VT[i].cre;
      @(negedge clk);
      checks++;
      if ({tx_empty, txs_valid, txs_data, rx_full, tx_flag, rx_flag, irq,
           tx_wr_err, rx_rd_err, nack_req, host_rdata} !==
          {VT[i].e_txe, VT[i].e_txv, VT[i].e_txd, VT[i].e_rxf, VT[i].e_txf,
           VT[i].e_rxfl, VT[i].e_irq, VT[i].e_terr, VT[i].e_rerr, VT[i].e_nk,
           VT[i].e_rdd}) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual txe%b txv%b txd%h rxf%b txf%b rxfl%b irq%b te%b re%b nk%b rd%h expected txe%b txv%b txd%h rxf%b txf%b rxfl%b irq%b te%b re%b nk%b rd%h",
          VT[i].req, i, tx_empty, txs_valid, txs_data, rx_full, tx_flag, rx_flag,
          irq, tx_wr_err, rx_rd_err, nack_req, host_rdata,
          VT[i].e_txe, VT[i].e_txv, VT[i].e_txd, VT[i].e_rxf, VT[i].e_txf,
          VT[i].e_rxfl, VT[i].e_irq, VT[i].e_terr, VT[i].e_rerr, VT[i].e_nk,
          VT[i].e_rdd);
      end
    end
    idle();

    // R4 enable masking: tx_flag=1 here, rx_flag=0
    tx_ie = 0; #1;
    chk("R4 tx masked", {7'd0, irq}, 8'd0);
    tx_ie = 1; #1;
    chk("R4 tx enabled", {7'd0, irq}, 8'd1);
    tx_ie = 0;
    rxs_valid = 1; rxs_data = 8'hC3;
    @(negedge clk); idle();
    chk("R4 rx enabled", {7'd0, irq}, 8'd1);
    rx_ie = 0; #1;
    chk("R4 both masked", {7'd0, irq}, 8'd0);
    tx_ie = 1; rx_ie = 1;

    // R9 error set beats clear in the same cycle
    host_wr = 1; host_wdata = 8'h01;
    @(negedge clk);
    host_wdata = 8'h02; clr_tx_err = 1;
    @(negedge clk); idle();
    chk("R9 set beats clear", {7'd0, tx_wr_err}, 8'd1);
    chk("R5 byte kept", txs_data, 8'h01);
    host_wr = 1; host_wdata = 8'h55; clr_tx_err = 1;
    @(negedge clk); idle();
    // R9 write while error set and slot full: error stays set, byte kept
    chk("R9 still set", {7'd0, tx_wr_err}, 8'd1);
    clr_tx_err = 1;
    @(negedge clk); idle();
    chk("R9 cleared", {7'd0, tx_wr_err}, 8'd0);
    chk("R2 offered again", {7'd0, txs_valid}, 8'd1);

    finish_run();
  end

endmodule